// File: doc/BRIEF.md
# Edge-Triggered Timestamp Capture Bank

This block holds a set of independent capture units that share one free-running timebase. Each unit watches one input chosen from a combined list of external pins and internal event lines. When the chosen input shows the configured transition, the unit stores the current timebase value and raises its interrupt line. Software then reads the stored time and clears the status. Typical uses are precise timing of audio/video events, feeding software clock-recovery loops and medium-speed signal analysis.

The timebase is a 31-bit counter that wraps to zero. A prescaler divides the system clock so that the counter advances once per tick; with a 40 MHz clock and `TICK_DIV = 3` the tick is 75 ns. Every source passes through a two-flop synchroniser before edge detection. Each unit runs a three-state status machine. `ST_IDLE` means nothing is pending. `ST_PENDING` means one capture has not yet been acknowledged. `ST_OVERRUN` means a further capture arrived while one was still pending. The transitions are `IDLE→PENDING` on capture, `PENDING→OVERRUN` on capture, `OVERRUN→OVERRUN` on capture, and `PENDING/OVERRUN→IDLE` on a clear. A capture and a clear in the same cycle go to `PENDING`.

Registers are reached through a flat address of the form `{unit, sel[1:0]}`. Writes take effect on a clock edge. Reads are combinational.

Top module: `tstamp_capture_bank`

## Requirements
- R1: After reset, every configuration, status and capture register reads zero, all interrupt lines are low and the timebase reads zero.
- R2: The timebase (sel 3, readable at any unit address) equals floor(N / TICK_DIV) modulo 2^31, where N is the number of clock edges since reset was released.
- R3: Configuration bits [8+SEL_W-1:8] pick the source: indices 0..NUM_PINS-1 are the pins and the following NUM_EVENTS indices are the event lines. An index at or beyond the number of sources never triggers.
- R4: Configuration bits [2:1] set the edge mode. 01 captures on rising, 10 on falling, 11 on either, and 00 on none. A transition that the mode does not select changes neither the status nor the capture register.
- R5: Suppose an input change is first sampled at clock edge k. The capture register is loaded at edge k+2 with the timebase value present before that edge, which is floor((k+1)/TICK_DIV).
- R6: The status register (sel 1) reads bit0 = pending and bit1 = overrun. A capture moves the unit IDLE→PENDING, and PENDING or OVERRUN→OVERRUN. Writing sel 1 with bit0 set returns the unit to IDLE. A capture on the same edge as that write leaves the unit in PENDING.
- R7: Interrupt line u is high exactly when unit u is enabled and its status is pending.
- R8: While configuration bit 0 (enable) is clear, the unit does not capture: its capture register and status keep their values.
- R9: The configuration register (sel 0) reads back the enable, edge and source fields at their positions and zero elsewhere. Addresses of units at or beyond NUM_UNITS read zero for sel 0..2 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | NUM_PINS | External pin inputs (asynchronous) |
| evt_in | input | NUM_EVENTS | Internal event lines |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | UNIT_W+2 | Write address {unit, sel} |
| wr_data | input | 32 | Write data |
| rd_addr | input | UNIT_W+2 | Read address {unit, sel} |
| rd_data | output | 32 | Read data (combinational) |
| irq | output | NUM_UNITS | Per-unit interrupt lines |

## Verification
The hardest case to reach is a new capture that lands on the very edge where the status clear is written. That case needs the input toggle and the register write to be spaced by exactly the synchroniser-plus-detector latency. The stimulus changes a pin right after a known edge, waits two edges, and then issues the clear, so the write falls on the capture edge. Overrun is reached by giving a second selected edge before any clear. A long random phase with sparse toggles, random clears and sweeping reads is compared every cycle against a behavioural model in the bench.

// File: rtl/tsb_pkg.sv
package tsb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'b00,
        ST_PENDING = 2'b01,
        ST_OVERRUN = 2'b11
    } unit_state_e;

    localparam logic [1:0] SEL_CFG     = 2'd0;
    localparam logic [1:0] SEL_STATUS  = 2'd1;
    localparam logic [1:0] SEL_CAPTURE = 2'd2;
    localparam logic [1:0] SEL_TIME    = 2'd3;

    localparam int DATA_W       = 32;
    localparam int CFG_EN_BIT   = 0;
    localparam int CFG_EDGE_LSB = 1;
    localparam int CFG_SRC_LSB  = 8;
endpackage

// File: rtl/tsb_timebase.sv
module tsb_timebase #(
    parameter int TB_W     = 31,
    parameter int TICK_DIV = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [TB_W-1:0] tb
);
    localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);

    logic [PRE_W-1:0] pre_q;
    logic             tick;

    assign tick = (pre_q == PRE_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
            tb    <= '0;
        end else begin
            pre_q <= tick ? '0 : pre_q + PRE_W'(1);
            if (tick) tb <= tb + TB_W'(1);
        end
    end

    AST_TB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(tb)); // R2
    AST_TB_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (tb == $past(tb) + TB_W'(1))); // R2
endmodule

// File: rtl/tsb_sync.sv
module tsb_sync #(
    parameter int N = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    logic [N-1:0] meta_q, sync_q, prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= din;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign rise = sync_q & ~prev_q;
    assign fall = ~sync_q & prev_q;

    AST_RISE_FROM_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        (rise != '0) |-> (($past(din, 2) & rise) == rise)); // R5
endmodule

// File: rtl/tsb_unit.sv
module tsb_unit
    import tsb_pkg::*;
#(
    parameter int NUM_SRC = 12,
    parameter int SEL_W   = 4,
    parameter int TB_W    = 31
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_en,
    input  logic [1:0]         cfg_edge,
    input  logic [SEL_W-1:0]   cfg_src,
    input  logic [NUM_SRC-1:0] rise_vec,
    input  logic [NUM_SRC-1:0] fall_vec,
    input  logic               clr,
    input  logic [TB_W-1:0]    tb,
    output logic [TB_W-1:0]    cap,
    output logic               pending,
    output logic               overrun,
    output logic               irq
);
    unit_state_e state_q, state_d;
    logic sel_rise, sel_fall, trig;

    always_comb begin
        sel_rise = 1'b0;
        sel_fall = 1'b0;
        if (int'(cfg_src) < NUM_SRC) begin
            sel_rise = rise_vec[cfg_src];
            sel_fall = fall_vec[cfg_src];
        end
    end

    assign trig = cfg_en & ((cfg_edge[0] & sel_rise) | (cfg_edge[1] & sel_fall));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (trig) state_d = ST_PENDING;
            end
            ST_PENDING: begin
                if (trig)     state_d = clr ? ST_PENDING : ST_OVERRUN;
                else if (clr) state_d = ST_IDLE;
            end
            ST_OVERRUN: begin
                if (trig)     state_d = clr ? ST_PENDING : ST_OVERRUN;
                else if (clr) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cap <= '0;
        else if (trig) cap <= tb;
    end

    always_comb begin
        pending = (state_q != ST_IDLE);
        overrun = (state_q == ST_OVERRUN);
        irq     = cfg_en & pending;
    end

    AST_OVR_AFTER_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OVERRUN) |-> ($past(state_q) != ST_IDLE)); // R6
    AST_DISABLED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> ($stable(cap) && ($past(clr) || $stable(state_q)))); // R8
endmodule

// File: rtl/tstamp_capture_bank.sv
module tstamp_capture_bank
    import tsb_pkg::*;
#(
    parameter int NUM_UNITS  = 12,
    parameter int NUM_PINS   = 8,
    parameter int NUM_EVENTS = 4,
    parameter int TB_W       = 31,
    parameter int TICK_DIV   = 3,
    localparam int UNIT_W    = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1,
    localparam int ADDR_W    = UNIT_W + 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_PINS-1:0]   pin_in,
    input  logic [NUM_EVENTS-1:0] evt_in,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [31:0]           wr_data,
    input  logic [ADDR_W-1:0]     rd_addr,
    output logic [31:0]           rd_data,
    output logic [NUM_UNITS-1:0]  irq
);
    localparam int NUM_SRC = NUM_PINS + NUM_EVENTS;
    localparam int SEL_W   = $clog2(NUM_SRC);

    logic [TB_W-1:0]    tb;
    logic [NUM_SRC-1:0] rise_vec, fall_vec;
    logic [UNIT_W-1:0]  wr_unit, rd_unit;
    logic [1:0]         wr_sel, rd_sel;

    logic               en_w   [NUM_UNITS];
    logic [1:0]         edge_w [NUM_UNITS];
    logic [SEL_W-1:0]   src_w  [NUM_UNITS];
    logic [TB_W-1:0]    cap_w  [NUM_UNITS];
    logic               pend_w [NUM_UNITS];
    logic               ovr_w  [NUM_UNITS];

    logic unused_wr_bits;
    assign unused_wr_bits = ^{wr_data[31:CFG_SRC_LSB+SEL_W], wr_data[CFG_SRC_LSB-1:3]};

    assign wr_unit = wr_addr[ADDR_W-1:2];
    assign wr_sel  = wr_addr[1:0];
    assign rd_unit = rd_addr[ADDR_W-1:2];
    assign rd_sel  = rd_addr[1:0];

    tsb_timebase #(.TB_W(TB_W), .TICK_DIV(TICK_DIV)) u_timebase (
        .clk(clk), .rst_n(rst_n), .tb(tb)
    );

    tsb_sync #(.N(NUM_SRC)) u_sync (
        .clk(clk), .rst_n(rst_n), .din({evt_in, pin_in}),
        .rise(rise_vec), .fall(fall_vec)
    );

    for (genvar g = 0; g < NUM_UNITS; g++) begin : gen_unit
        logic             en_q;
        logic [1:0]       edge_q;
        logic [SEL_W-1:0] src_q;
        logic             hit;
        logic             clr;

        assign hit = wr_en && (wr_unit == UNIT_W'(g));
        assign clr = hit && (wr_sel == SEL_STATUS) && wr_data[0];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                en_q   <= 1'b0;
                edge_q <= 2'b00;
                src_q  <= '0;
            end else if (hit && (wr_sel == SEL_CFG)) begin
                en_q   <= wr_data[CFG_EN_BIT];
                edge_q <= wr_data[CFG_EDGE_LSB +: 2];
                src_q  <= wr_data[CFG_SRC_LSB +: SEL_W];
            end
        end

        assign en_w[g]   = en_q;
        assign edge_w[g] = edge_q;
        assign src_w[g]  = src_q;

        tsb_unit #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W), .TB_W(TB_W)) u_unit (
            .clk(clk), .rst_n(rst_n),
            .cfg_en(en_q), .cfg_edge(edge_q), .cfg_src(src_q),
            .rise_vec(rise_vec), .fall_vec(fall_vec),
            .clr(clr), .tb(tb),
            .cap(cap_w[g]), .pending(pend_w[g]), .overrun(ovr_w[g]),
            .irq(irq[g])
        );
    end

    always_comb begin
        rd_data = '0;
        if (rd_sel == SEL_TIME) begin
            rd_data = DATA_W'(tb);
        end else if (int'(rd_unit) < NUM_UNITS) begin
            case (rd_sel)
                SEL_CFG: begin
                    rd_data[CFG_EN_BIT]             = en_w[rd_unit];
                    rd_data[CFG_EDGE_LSB +: 2]      = edge_w[rd_unit];
                    rd_data[CFG_SRC_LSB +: SEL_W]   = src_w[rd_unit];
                end
                SEL_STATUS:  rd_data[1:0] = {ovr_w[rd_unit], pend_w[rd_unit]};
                SEL_CAPTURE: rd_data      = DATA_W'(cap_w[rd_unit]);
                default:     rd_data      = '0;
            endcase
        end
    end
endmodule

// File: tb/sim_tstamp_capture_bank.sv
module sim_tstamp_capture_bank;
    localparam int NU  = 12;
    localparam int NP  = 8;
    localparam int NE  = 4;
    localparam int NS  = 12;
    localparam int DIV = 3;
    localparam int AW  = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pin_in = '0;
    logic [NE-1:0] evt_in = '0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [31:0]   wr_data = '0;
    logic [31:0]   rd_data;
    logic [NU-1:0] irq;

    always #10 clk = ~clk;

    tstamp_capture_bank u0 (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .evt_in(evt_in),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
    );

    // behavioural reference state
    bit          m_en   [NU];
    int          m_edge [NU];
    int          m_src  [NU];
    longint      m_cap  [NU];
    bit          m_pend [NU];
    bit          m_ovr  [NU];
    longint      ncyc;
    bit [NS-1:0] hq[$];
    int          tests = 0;
    int          fails = 0;
    bit          done = 1'b0;

    task automatic chk(input string tag, input longint got, input longint exp);
        tests++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    function automatic longint exp_read(input logic [AW-1:0] a);
        int u = int'(a[AW-1:2]);
        int s = int'(a[1:0]);
        if (s == 3) return (ncyc / DIV) % (longint'(1) << 31);
        if (u >= NU) return 0;
        case (s)
            0:       return longint'(m_src[u] << 8) | longint'(m_edge[u] << 1) | longint'(m_en[u]);
            1:       return longint'({m_ovr[u], m_pend[u]});
            default: return m_cap[u];
        endcase
    endfunction

    function automatic string sel_tag(input logic [1:0] s);
        case (s)
            2'd0:    return "R9 config readback";
            2'd1:    return "R6 status";
            2'd2:    return "R5 capture value";
            default: return "R2 timebase";
        endcase
    endfunction

    always @(posedge clk) begin : model
        bit [NS-1:0] older, newer;
        longint tbv;
        bit r, f, trig, clr;
        int s, wu;
        if (!rst_n) begin
            for (int u = 0; u < NU; u++) begin
                m_en[u] = 0; m_edge[u] = 0; m_src[u] = 0;
                m_cap[u] = 0; m_pend[u] = 0; m_ovr[u] = 0;
            end
            hq = '{12'h0, 12'h0, 12'h0};
            ncyc = 0;
        end else begin
            older = hq[0];
            newer = hq[1];
            tbv = (ncyc / DIV) % (longint'(1) << 31);
            wu = int'(wr_addr[AW-1:2]);
            for (int u = 0; u < NU; u++) begin
                s = m_src[u];
                r = 0; f = 0;
                if (s < NS) begin
                    r = newer[s] & ~older[s];
                    f = ~newer[s] & older[s];
                end
                trig = m_en[u] && ((m_edge[u][0] && r) || (m_edge[u][1] && f));
                clr  = wr_en && (wu == u) && (wr_addr[1:0] == 2'd1) && wr_data[0];
                if (trig) begin
                    m_cap[u] = tbv;
                    if (clr)            begin m_pend[u] = 1; m_ovr[u] = 0; end
                    else if (m_pend[u]) m_ovr[u] = 1;
                    else                m_pend[u] = 1;
                end else if (clr) begin
                    m_pend[u] = 0; m_ovr[u] = 0;
                end
            end
            if (wr_en && wr_addr[1:0] == 2'd0 && wu < NU) begin
                m_en[wu]   = wr_data[0];
                m_edge[wu] = int'(wr_data[2:1]);
                m_src[wu]  = int'(wr_data[11:8]);
            end
            void'(hq.pop_front());
            hq.push_back({evt_in, pin_in});
            ncyc++;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin : cmp
        logic [NU-1:0] ei;
        if (rst_n && !done) begin
            for (int u = 0; u < NU; u++) ei[u] = m_en[u] & m_pend[u];
            chk("R7 irq lines", longint'(irq), longint'(ei));
            chk(sel_tag(rd_addr[1:0]), longint'(rd_data), exp_read(rd_addr));
        end
    end

    task automatic step();
        @(posedge clk);
        #3;
    endtask

    task automatic wr(input int unit, input int sel, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = AW'((unit << 2) | sel); wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic rd(input int unit, input int sel, output logic [31:0] v);
        rd_addr = AW'((unit << 2) | sel);
        @(negedge clk);
        v = rd_data;
        step();
    endtask

    task automatic irq_bit(input int unit, output logic v);
        @(negedge clk);
        v = irq[unit];
        step();
    endtask

    initial begin : watchdog
        #(20 * 200000);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog (all requirements): got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] v;
        logic        b;
        longint      m, c0, t0, n0;
        repeat (3) @(posedge clk);
        #3 rst_n = 1'b1;
        step();

        // R1: reset state
        for (int u = 0; u < NU; u++)
            for (int s = 0; s < 3; s++) begin
                rd(u, s, v);
                chk("R1 reset register", longint'(v), 0);
            end
        @(negedge clk);
        chk("R1 reset irq", longint'(irq), 0);
        step();

        // R5/R4: rising capture on pin 0
        wr(0, 0, 32'h003);
        m = ncyc;
        pin_in[0] = 1'b1;
        repeat (4) step();
        rd(0, 2, v); chk("R5 capture latency", longint'(v), (m + 2) / DIV);
        c0 = longint'(v);
        rd(0, 1, v); chk("R6 pending after capture", longint'(v), 1);
        irq_bit(0, b); chk("R7 irq raised", longint'(b), 1);

        // R4: falling ignored in rising mode
        pin_in[0] = 1'b0;
        repeat (5) step();
        rd(0, 1, v); chk("R4 falling ignored status", longint'(v), 1);
        rd(0, 2, v); chk("R4 falling ignored capture", longint'(v), c0);

        // R6: overrun
        pin_in[0] = 1'b1;
        repeat (5) step();
        rd(0, 1, v); chk("R6 overrun", longint'(v), 3);

        // R6/R7: clear
        wr(0, 1, 32'h1);
        rd(0, 1, v); chk("R6 cleared", longint'(v), 0);
        irq_bit(0, b); chk("R7 irq dropped", longint'(b), 0);

        // R6: capture coinciding with clear
        wr(0, 0, 32'h007);
        pin_in[0] = 1'b0;
        repeat (5) step();
        m = ncyc;
        pin_in[0] = 1'b1;
        step(); step();
        wr(0, 1, 32'h1);
        rd(0, 1, v); chk("R6 clear with capture", longint'(v), 1);
        rd(0, 2, v); chk("R5 either-edge capture", longint'(v), (m + 2) / DIV);
        c0 = longint'(v);

        // R8: disabled unit holds state
        wr(0, 0, 32'h006);
        pin_in[0] = 1'b0; repeat (5) step();
        pin_in[0] = 1'b1; repeat (5) step();
        rd(0, 2, v); chk("R8 disabled capture held", longint'(v), c0);
        rd(0, 1, v); chk("R8 disabled status held", longint'(v), 1);
        irq_bit(0, b); chk("R7 irq gated by enable", longint'(b), 0);

        // R3: source selection
        wr(5, 0, 32'h903);
        pin_in[1] = 1'b1; repeat (5) step();
        rd(5, 1, v); chk("R3 other source ignored", longint'(v), 0);
        evt_in[1] = 1'b1; repeat (5) step();
        rd(5, 1, v); chk("R3 event source captured", longint'(v), 1);
        wr(6, 0, 32'hD07);
        pin_in = ~pin_in; evt_in = ~evt_in; repeat (5) step();
        pin_in = ~pin_in; evt_in = ~evt_in; repeat (5) step();
        rd(6, 1, v); chk("R3 out-of-range source", longint'(v), 0);

        // R9: register map
        rd(5, 0, v); chk("R9 config fields", longint'(v), 32'h903);
        wr(3, 0, 32'hFFFF_FFFF);
        rd(3, 0, v); chk("R9 config unused bits zero", longint'(v), 32'hF07);
        wr(3, 0, 32'h0);
        wr(13, 0, 32'h0000_0F07);
        rd(13, 0, v); chk("R9 unused unit reads zero", longint'(v), 0);

        // R2: timebase
        rd_addr = AW'(3);
        @(negedge clk); t0 = longint'(rd_data); n0 = ncyc;
        chk("R2 timebase value", t0, n0 / DIV);
        step();
        repeat (30) step();
        @(negedge clk);
        chk("R2 timebase advance", longint'(rd_data) - t0, (ncyc / DIV) - (n0 / DIV));
        step();

        // random phase, compared every cycle by the model
        for (int u = 0; u < NU; u++)
            wr(u, 0, {20'h0, 4'($urandom % 16), 5'h0, 2'($urandom % 4), 1'($urandom % 4 != 0)});
        for (int i = 0; i < 4000; i++) begin
            pin_in ^= NP'($urandom & $urandom & $urandom);
            evt_in ^= NE'($urandom & $urandom & $urandom);
            rd_addr = AW'($urandom % 64);
            if ($urandom % 16 == 0)
                wr(int'($urandom % 16), 1, 32'($urandom % 2));
            else if ($urandom % 200 == 0)
                wr(int'($urandom % 12), 0, {20'h0, 4'($urandom % 16), 5'h0, 2'($urandom % 4), 1'($urandom % 2)});
            else
                step();
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule